// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Random Refill Slot

This block holds sixteen recently used page translations. Each lookup presents a 20-bit virtual page number. The block compares that number against the tag of every valid entry at once, because in a fully associative buffer the whole page number is the tag. When one entry matches, the block returns that entry's physical page number and dirty status in the same cycle, so the memory access can start without delay.

A lookup that finds no match does not start a refill. Instead the block raises a miss exception and captures the faulting page number for a software handler. A store lookup that hits an entry whose dirty bit is clear raises a separate modify exception, so the handler can set the dirty bit. The handler installs entries through a write port, which accepts writes only in supervisor mode. A new tag goes into a slot picked by a free-running pseudo-random sequence. A tag that is already present is overwritten in place. A flush input invalidates every entry in one cycle.

The exception outputs come from a three-state machine. `ST_CLEAN` means the previous cycle produced no fault. `ST_MISS` means the previous lookup missed. `ST_MODIFY` means the previous lookup was a store that hit a clean entry. Every clock edge chooses the next state from that cycle's lookup alone. A missing lookup moves to `ST_MISS`. A store hit on a clean entry moves to `ST_MODIFY`. Any other cycle, or no lookup at all, moves to `ST_CLEAN`. Every state can take each of these transitions, and reset enters `ST_CLEAN`.

Top module: `fa_tlb`

## Requirements
- R1: After reset, every entry is invalid, `miss_exc` and `mod_exc` are 0 and `fault_vpn` is 0.
- R2: When `lk_valid` is 1 and a valid entry holds `lk_vpn`, `hit` is 1 in the same cycle and `hit_ppn` and `hit_dirty` show that entry's contents. When there is no hit, all three outputs are 0.
- R3: A lookup with no matching valid entry sets `miss_exc` to 1 in the next cycle, for one cycle, and `fault_vpn` captures the lookup's page number.
- R4: A write with `wr_en` and `sup_mode` both at 1 and a tag not already present goes into the slot given by a 4-bit sequence. The sequence resets to 0000. On each clock edge after reset it shifts left and takes s[3]^s[2]^(s[2:0]==000) as its new bit 0, which visits all 16 values. Lookups see the new entry from the next cycle on.
- R5: A write with `sup_mode` at 0 has no effect on the contents.
- R6: A supervisor write whose tag is already valid overwrites that entry's page number and dirty bit. It uses no new slot, so the random slot's previous contents survive.
- R7: A lookup with `lk_store` at 1 that hits an entry whose dirty bit is 0 sets `mod_exc` in the next cycle and captures `fault_vpn`. A store hit on a dirty entry, or a load hit, raises no exception.
- R8: `flush` invalidates every entry at the next edge. A write in the same cycle is dropped.
- R9: `miss_exc` and `mod_exc` are never both 1. `fault_vpn` changes only in the cycle after a miss or modify fault.
- R10: A lookup in the same cycle as a write or flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is for a store |
| lk_vpn | input | 20 | Lookup virtual page number |
| hit | output | 1 | Lookup matched a valid entry |
| hit_ppn | output | 20 | Physical page number of the match |
| hit_dirty | output | 1 | Dirty bit of the match |
| miss_exc | output | 1 | Miss exception, one cycle after the lookup |
| mod_exc | output | 1 | Modify exception, one cycle after the lookup |
| fault_vpn | output | 20 | Page number of the last faulting lookup |
| wr_en | input | 1 | Install request |
| sup_mode | input | 1 | Processor is in supervisor mode |
| wr_vpn | input | 20 | Tag to install |
| wr_ppn | input | 20 | Physical page number to install |
| wr_dirty | input | 1 | Dirty bit to install |

## Verification
The bench first fills the buffer past its capacity, which forces random-slot evictions. A slot choice that skipped or repeated a sequence value would leave the wrong tag resident, and later lookups would hit or miss differently from the model. It rewrites a tag that is already resident. A design that ignored the existing match would create a duplicate or evict an unrelated entry. It also drives a lookup in the same cycle as a write or a flush, and it combines a flush with a write. A design with the wrong ordering would hit too early or keep the written entry. Store lookups go to both clean and dirty entries, and user-mode writes are mixed into random traffic. These catch a modify exception raised on the wrong status and a write that ignores the privilege check.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_MISS   = 2'd1,
        ST_MODIFY = 2'd2
    } fault_state_e;

endpackage

// File: rtl/tlb_slot_lfsr.sv
module tlb_slot_lfsr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] slot
);
    logic [W-1:0] st;
    logic         fb_base;
    logic         fb;

    generate
        if (W == 3) begin : g_w3
            assign fb_base = st[2] ^ st[1];
        end else if (W == 5) begin : g_w5
            assign fb_base = st[4] ^ st[2];
        end else begin : g_w4
            assign fb_base = st[W-1] ^ st[W-2];
        end
    endgenerate

    // the extra term splices the all-zero state into the cycle
    assign fb = fb_base ^ (st[W-2:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= '0;
        else        st <= {st[W-2:0], fb};
    end

    assign slot = st;
endmodule

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [TAG_W-1:0]   tags [ENTRIES],
    input  logic [TAG_W-1:0]   key,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    logic [ENTRIES-1:0] match;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign match[i] = valid[i] && (tags[i] == key);
        end
    endgenerate

    // tags are unique among valid entries, so an OR of indices encodes
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |match;
endmodule

// File: rtl/tlb_fault_fsm.sv
module tlb_fault_fsm
    import fa_tlb_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_store,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             hit,
    input  logic             hit_dirty,
    output logic             miss_exc,
    output logic             mod_exc,
    output logic [VPN_W-1:0] fault_vpn
);
    fault_state_e state, state_nx;

    always_comb begin
        if (lk_valid && !hit)                        state_nx = ST_MISS;
        else if (lk_valid && lk_store && !hit_dirty) state_nx = ST_MODIFY;
        else                                         state_nx = ST_CLEAN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_CLEAN;
            fault_vpn <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != ST_CLEAN) fault_vpn <= lk_vpn;
        end
    end

    always_comb begin
        miss_exc = 1'b0;
        mod_exc  = 1'b0;
        unique case (state)
            ST_CLEAN:  ;
            ST_MISS:   miss_exc = 1'b1;
            ST_MODIFY: mod_exc  = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb #(
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic             lk_store,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_dirty,
    output logic             miss_exc,
    output logic             mod_exc,
    output logic [VPN_W-1:0] fault_vpn,
    input  logic             wr_en,
    input  logic             sup_mode,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_dirty
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] e_valid;
    logic [ENTRIES-1:0] e_dirty;
    logic [VPN_W-1:0]   e_vpn [ENTRIES];
    logic [PPN_W-1:0]   e_ppn [ENTRIES];

    logic               lk_any, wr_any, wr_take;
    logic [IDX_W-1:0]   lk_idx, wr_idx, rnd_slot, wr_slot;

    tlb_slot_lfsr #(.W(IDX_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .slot(rnd_slot)
    );

    tlb_cam_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
        .valid(e_valid), .tags(e_vpn), .key(lk_vpn), .any(lk_any), .idx(lk_idx)
    );

    tlb_cam_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_wr_cam (
        .valid(e_valid), .tags(e_vpn), .key(wr_vpn), .any(wr_any), .idx(wr_idx)
    );

    assign hit       = lk_valid && lk_any;
    assign hit_ppn   = hit ? e_ppn[lk_idx] : '0;
    assign hit_dirty = hit && e_dirty[lk_idx];

    assign wr_take = wr_en && sup_mode && !flush;
    assign wr_slot = wr_any ? wr_idx : rnd_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_dirty <= '0;
        end else if (flush) begin
            e_valid <= '0;
        end else if (wr_take) begin
            e_valid[wr_slot] <= 1'b1;
            e_dirty[wr_slot] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_take) begin
            e_vpn[wr_slot] <= wr_vpn;
            e_ppn[wr_slot] <= wr_ppn;
        end
    end

    tlb_fault_fsm #(.VPN_W(VPN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_store(lk_store), .lk_vpn(lk_vpn),
        .hit(hit), .hit_dirty(hit_dirty),
        .miss_exc(miss_exc), .mod_exc(mod_exc), .fault_vpn(fault_vpn)
    );
endmodule

// File: rtl/fa_tlb_chk.sv
module fa_tlb_chk #(
    parameter int VPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             lk_valid,
    input logic             lk_store,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             hit,
    input logic             hit_dirty,
    input logic             miss_exc,
    input logic             mod_exc,
    input logic [VPN_W-1:0] fault_vpn,
    input logic             wr_en,
    input logic             sup_mode,
    input logic [VPN_W-1:0] wr_vpn
);
    // R3
    miss_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !hit) |=> (miss_exc && fault_vpn == $past(lk_vpn)));

    // R7
    modify_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_store && hit && !hit_dirty) |=> (mod_exc && !miss_exc));

    // R4
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sup_mode && !flush) ##1 (lk_valid && lk_vpn == $past(wr_vpn)) |-> hit);

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 lk_valid |-> !hit);

    // R9
    single_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({miss_exc, mod_exc}) <= 1);

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> $stable(fault_vpn));
endmodule

bind fa_tlb fa_tlb_chk #(.VPN_W(VPN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_store(lk_store), .lk_vpn(lk_vpn), .hit(hit), .hit_dirty(hit_dirty),
    .miss_exc(miss_exc), .mod_exc(mod_exc), .fault_vpn(fault_vpn),
    .wr_en(wr_en), .sup_mode(sup_mode), .wr_vpn(wr_vpn)
);

// File: tb/fa_tlb_bench.sv
`timescale 1ns/1ps
module fa_tlb_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, lk_valid = 1'b0, lk_store = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        hit, hit_dirty, miss_exc, mod_exc;
    logic [19:0] hit_ppn, fault_vpn;
    logic        wr_en = 1'b0, sup_mode = 1'b0, wr_dirty = 1'b0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit          m_val [N];
    bit          m_dirty [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_ppn [N];
    logic [3:0]  m_lfsr = 4'h0;
    bit          e_miss = 1'b0, e_mod = 1'b0;
    logic [19:0] e_fault = '0;

    always #2.5 clk = ~clk;

    fa_tlb u_fa_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_store(lk_store), .lk_vpn(lk_vpn), .hit(hit), .hit_ppn(hit_ppn),
        .hit_dirty(hit_dirty), .miss_exc(miss_exc), .mod_exc(mod_exc),
        .fault_vpn(fault_vpn), .wr_en(wr_en), .sup_mode(sup_mode),
        .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_dirty(wr_dirty)
    );

    function automatic int find(logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic logic [3:0] lfsr_step(logic [3:0] s);
        logic fb;
        fb = s[3] ^ s[2] ^ (s[2:0] == 3'b000);
        return {s[2:0], fb};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; lk_valid = 0; lk_store = 0; wr_en = 0; sup_mode = 0; wr_dirty = 0;
    endtask

    task automatic look(logic [19:0] v, bit st);
        lk_valid = 1; lk_vpn = v; lk_store = st;
    endtask

    task automatic put(logic [19:0] v, logic [19:0] p, bit d, bit sup);
        wr_en = 1; wr_vpn = v; wr_ppn = p; wr_dirty = d; sup_mode = sup;
    endtask

    // one clock: inputs are already driven after a falling edge
    task automatic cyc(string req);
        int li, slot;
        bit eh;
        #1;
        li = lk_valid ? find(lk_vpn) : -1;
        eh = (li >= 0);
        check(req, "hit", 32'(hit), 32'(eh));
        check(req, "hit_ppn", 32'(hit_ppn), eh ? 32'(m_ppn[li]) : 32'h0);
        check(req, "hit_dirty", 32'(hit_dirty), eh ? 32'(m_dirty[li]) : 32'h0);
        @(posedge clk);
        e_miss = lk_valid && !eh;
        e_mod  = lk_valid && lk_store && eh && !m_dirty[li];
        if (e_miss || e_mod) e_fault = lk_vpn;
        if (flush) begin
            for (int i = 0; i < N; i++) m_val[i] = 0;
        end else if (wr_en && sup_mode) begin
            slot = find(wr_vpn);
            if (slot < 0) slot = int'(m_lfsr);
            m_val[slot] = 1; m_dirty[slot] = wr_dirty;
            m_vpn[slot] = wr_vpn; m_ppn[slot] = wr_ppn;
        end
        m_lfsr = lfsr_step(m_lfsr);
        @(negedge clk);
        check(req, "miss_exc", 32'(miss_exc), 32'(e_miss));
        check(req, "mod_exc", 32'(mod_exc), 32'(e_mod));
        check(req, "fault_vpn", 32'(fault_vpn), 32'(e_fault));
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5a17));
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_dirty[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "miss_exc", 32'(miss_exc), 0);
        check("R1", "mod_exc", 32'(mod_exc), 0);
        check("R1", "fault_vpn", 32'(fault_vpn), 0);
        rst_n = 1;
        look(20'h00A11, 0); cyc("R1");
        // R5 user-mode write ignored
        put(20'h00A11, 20'h12345, 0, 0); cyc("R5");
        look(20'h00A11, 0); cyc("R5");
        // R4 supervisor install, R2 hit
        put(20'h00A11, 20'h12345, 0, 1); cyc("R4");
        look(20'h00A11, 0); cyc("R2");
        // R7 store on clean entry, then dirty overwrite (R6)
        look(20'h00A11, 1); cyc("R7");
        put(20'h00A11, 20'h54321, 1, 1); cyc("R6");
        look(20'h00A11, 1); cyc("R7");
        // R10 lookup alongside write sees old contents
        look(20'h00B22, 0); put(20'h00B22, 20'h0BEEF, 1, 1); cyc("R10");
        look(20'h00B22, 0); cyc("R10");
        // R4 overfill forces evictions through the random slot
        for (int k = 0; k < 20; k++) begin
            put(20'h10000 + 20'(k * 37), 20'(k * 911 + 5), k[0], 1); cyc("R4");
        end
        for (int k = 0; k < 20; k++) begin
            look(20'h10000 + 20'(k * 37), 0); cyc("R4");
        end
        // R6 rewrite of resident tag
        put(20'h10000 + 20'(19 * 37), 20'hFACE0, 0, 1); cyc("R6");
        for (int k = 0; k < 20; k++) begin
            look(20'h10000 + 20'(k * 37), 0); cyc("R6");
        end
        // R8 flush beats write
        flush = 1; put(20'h00C33, 20'h00777, 0, 1); cyc("R8");
        look(20'h00C33, 0); cyc("R8");
        look(20'h10000, 0); cyc("R8");
        // R9 fault address held while idle
        look(20'h00D44, 0); cyc("R9");
        cyc("R9");
        cyc("R9");
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [19:0] pool_v;
            flush = ($urandom % 100) == 0;
            if (($urandom % 3) == 0) begin
                pool_v = 20'h00040 + 20'(($urandom % 24) * 20'h1357);
                put(pool_v, 20'($urandom), 1'($urandom), ($urandom % 8) != 0);
            end
            if (($urandom % 4) != 0) begin
                pool_v = 20'h00040 + 20'(($urandom % 24) * 20'h1357);
                look(pool_v, 1'($urandom));
            end
            cyc("RND");
        end
        finish_run();
    end
endmodule